// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C bus target that gives a controller access to a small bank of byte-wide registers. It runs from a fast system clock and passes the SCL and SDA lines through synchronizers. It watches for bus conditions on the synchronized lines: START, repeated START and STOP. It takes in the address byte after each START. It answers only when the address equals its own address parameter and that address is not in a reserved range. It drives SDA in open-drain fashion. The output value is tied low and a separate enable pulls the line.

In a write, the first data byte after the address loads an internal register pointer. Each later byte is stored at the pointer, and the pointer then advances, wrapping at the end of the bank. A read starts at the current pointer and returns one byte per acknowledge from the controller. The pointer advances for each byte sent. The read ends at the first NACK. A repeated START keeps the pointer, so a pointer-only write followed by a repeated START gives a random-access read. A STOP returns the pointer to zero.

Top module: `i2c_regtarget`

## Requirements
- R1: After reset, SDA is released (`sda_oe` low), every register holds 0x00 and the pointer is 0.
- R2: A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP. A START seen during a transaction is a repeated START: it starts a new address phase without a STOP and keeps the pointer.
- R3: The target acknowledges an address byte by holding SDA low through the ninth SCL high period. It does this only when bits 7..1 of the byte equal `OWN_ADDR`. On a mismatch, SDA stays released until the next START or STOP.
- R4: The target changes its SDA drive only while SCL is low.
- R5: An address whose upper four bits (bits 6..3 of the 7-bit address) are 0000 or 1111 is never acknowledged, even when it equals `OWN_ADDR`.
- R6: When bit 0 of the address byte is 0 (write), the target acknowledges every data byte. The first data byte loads the pointer from its low log2(NUM_REGS) bits. Each later byte is written at the pointer, which then increments modulo NUM_REGS.
- R7: When bit 0 of the address byte is 1 (read), the target sends bytes MSB first, starting at the pointer. It increments the pointer modulo NUM_REGS after each byte, and sends another byte each time the controller acknowledges.
- R8: A NACK from the controller ends the read. SDA stays released for any further clocks until the next START or STOP.
- R9: A START followed by a STOP with no address byte between them changes no register.
- R10: A STOP ends any transaction, releases SDA and sets the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| sda_o | output | 1 | SDA output value, always 0 (open drain) |
| sda_oe | output | 1 | SDA pull-down enable; high pulls the line low |

## Verification
Two things land in the same clock cycle: the store of a data byte into the register bank, and the advance of the pointer. Both happen on the SCL fall that opens the acknowledge clock. The bench provokes this with a burst write that starts two entries below the top of the bank, so the pointer wraps in the middle of the burst. It then reads the same span back across the wrap, with a repeated START after a pointer-only write. A scoreboard judges every acknowledge bit and every returned byte against a register model kept in the bench.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int BYTE_W    = 8;
   localparam int BIT_CNT_W = 4;
   localparam int ADDR_W    = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDATA,
      ST_WACK,
      ST_RDATA,
      ST_RACK,
      ST_SKIP
   } tgt_state_t;

   // Upper nibble all zeros or all ones marks a reserved address.
   function automatic logic addr_reserved(input logic [ADDR_W-1:0] a);
      return (a[ADDR_W-1 -: 4] == 4'b0000) || (a[ADDR_W-1 -: 4] == 4'b1111);
   endfunction
endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   initial begin
      assert (STAGES >= 2) else $error("linesync needs at least two stages");
   end

   // Bit 1 carries SCL, bit 0 carries SDA; idle bus reads high.
   for (genvar i = 0; i < STAGES; i++) begin : g_st
      logic [1:0] q;
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= 2'b11;
            else        q <= {scl_in, sda_in};
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= 2'b11;
            else        q <= g_st[i-1].q;
      end
   end

   logic [1:0] last;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last <= 2'b11;
      else        last <= g_st[STAGES-1].q;

   assign scl_s     = g_st[STAGES-1].q[1];
   assign sda_s     = g_st[STAGES-1].q[0];
   assign scl_rise  =  scl_s & ~last[1];
   assign scl_fall  = ~scl_s &  last[1];
   assign start_det =  scl_s &  last[1] &  last[0] & ~sda_s;
   assign stop_det  =  scl_s &  last[1] & ~last[0] &  sda_s;
endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile #(
   parameter int NUM_REGS = 8,
   parameter int BYTE_W   = 8,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [BYTE_W-1:0] rd_data
);
   logic [NUM_REGS-1:0][BYTE_W-1:0] bank;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)                              q <= '0;
         else if (wr_en && wr_idx == IDX_W'(r))   q <= wr_data;
      assign bank[r] = q;
   end

   assign rd_data = bank[rd_idx];

   assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (bank[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h42,
   parameter int IDX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  ptr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              sda_drive
);
   localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

   tgt_state_t           state;
   logic [BIT_CNT_W-1:0] bit_cnt;
   logic [BYTE_W-1:0]    shreg;
   logic [BYTE_W-1:0]    tx;
   logic                 rw;
   logic                 ptr_pending;
   logic                 nack_seen;
   logic                 addr_hit;
   logic                 byte_end;

   assign addr_hit = (shreg[BYTE_W-1:1] == OWN_ADDR) && !addr_reserved(shreg[BYTE_W-1:1]);
   assign byte_end = scl_fall && (bit_cnt == LAST_BIT);
   assign wr_data  = shreg;
   assign wr_en    = (state == ST_WDATA) && byte_end && !ptr_pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         bit_cnt     <= '0;
         shreg       <= '0;
         tx          <= '0;
         rw          <= 1'b0;
         ptr_pending <= 1'b0;
         nack_seen   <= 1'b1;
         ptr         <= '0;
         sda_drive   <= 1'b0;
      end else if (stop_det) begin
         state       <= ST_IDLE;
         bit_cnt     <= '0;
         ptr_pending <= 1'b0;
         ptr         <= '0;
         sda_drive   <= 1'b0;
      end else if (start_det) begin
         state       <= ST_ADDR;
         bit_cnt     <= '0;
         ptr_pending <= 1'b0;
         sda_drive   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE, ST_SKIP: ;
            ST_ADDR: begin
               if (scl_rise) begin
                  shreg   <= {shreg[BYTE_W-2:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (byte_end) begin
                  if (addr_hit) begin
                     state     <= ST_AACK;
                     rw        <= shreg[0];
                     sda_drive <= 1'b1;
                  end else begin
                     state     <= ST_SKIP;
                  end
               end
            end
            ST_AACK: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  if (rw) begin
                     tx        <= rd_data;
                     sda_drive <= ~rd_data[BYTE_W-1];
                     ptr       <= ptr + 1'b1;
                     state     <= ST_RDATA;
                  end else begin
                     sda_drive   <= 1'b0;
                     ptr_pending <= 1'b1;
                     state       <= ST_WDATA;
                  end
               end
            end
            ST_WDATA: begin
               if (scl_rise) begin
                  shreg   <= {shreg[BYTE_W-2:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (byte_end) begin
                  sda_drive <= 1'b1;
                  state     <= ST_WACK;
                  if (ptr_pending) begin
                     ptr         <= shreg[IDX_W-1:0];
                     ptr_pending <= 1'b0;
                  end else begin
                     ptr <= ptr + 1'b1;
                  end
               end
            end
            ST_WACK: begin
               if (scl_fall) begin
                  sda_drive <= 1'b0;
                  bit_cnt   <= '0;
                  state     <= ST_WDATA;
               end
            end
            ST_RDATA: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (byte_end) begin
                  sda_drive <= 1'b0;
                  state     <= ST_RACK;
               end else if (scl_fall && bit_cnt != '0) begin
                  tx        <= {tx[BYTE_W-2:0], 1'b0};
                  sda_drive <= ~tx[BYTE_W-2];
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  nack_seen <= sda_s;
               end else if (scl_s) begin
                  nack_seen <= nack_seen | sda_s;
               end else if (scl_fall) begin
                  if (!nack_seen) begin
                     tx        <= rd_data;
                     sda_drive <= ~rd_data[BYTE_W-1];
                     ptr       <= ptr + 1'b1;
                     bit_cnt   <= '0;
                     state     <= ST_RDATA;
                  end else begin
                     state     <= ST_SKIP;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Drive edges only follow a low SCL, except releases forced by bus conditions.
   assert_drive_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_drive != $past(sda_drive)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

   assert_released_when_unselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP || state == ST_IDLE) |-> !sda_drive);

   assert_no_reserved_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_AACK) |-> !addr_reserved(shreg[BYTE_W-1:1]));

   assert_byte_then_ack_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RDATA && byte_end && !start_det && !stop_det) |=> (state == ST_RACK && !sda_drive));

   assert_nack_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RACK && scl_fall && nack_seen && !start_det && !stop_det) |=> (!sda_drive && state == ST_SKIP));

   assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (ptr == '0 && !sda_drive && state == ST_IDLE));

   assert_write_ack_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WACK && !scl_fall && !start_det && !stop_det) |=> sda_drive);
endmodule

// File: rtl/i2c_regtarget.sv
module i2c_regtarget #(
   parameter logic [6:0] OWN_ADDR    = 7'h42,
   parameter int         NUM_REGS    = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic sda_oe
);
   localparam int IDX_W  = $clog2(NUM_REGS);
   localparam int BYTE_W = i2c_tgt_pkg::BYTE_W;

   initial begin
      assert (NUM_REGS >= 2 && (NUM_REGS & (NUM_REGS - 1)) == 0)
         else $error("NUM_REGS must be a power of two, at least 2");
      assert (NUM_REGS <= 256) else $error("NUM_REGS must fit an 8-bit pointer byte");
   end

   logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic              wr_en;
   logic [IDX_W-1:0]  ptr;
   logic [BYTE_W-1:0] wr_data, rd_data;
   logic              sda_drive;

   i2c_tgt_linesync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_i),
      .sda_in    (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_tgt_engine #(.OWN_ADDR(OWN_ADDR), .IDX_W(IDX_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .ptr       (ptr),
      .wr_data   (wr_data),
      .sda_drive (sda_drive)
   );

   i2c_tgt_regfile #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (ptr),
      .wr_data (wr_data),
      .rd_idx  (ptr),
      .rd_data (rd_data)
   );

   assign sda_o  = 1'b0;
   assign sda_oe = sda_drive;
endmodule

// File: tb/tb_i2c_regtarget.sv
module tb_i2c_regtarget;
   localparam int         Q      = 10;
   localparam logic [6:0] MYADDR = 7'h42;
   localparam int         NREG   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_c = 1'b1;
   logic sda_c = 1'b1;
   logic sda_o, sda_oe, rsv_o, rsv_oe;
   logic sda_line;

   assign sda_line = sda_c & ~(sda_oe & ~sda_o) & ~(rsv_oe & ~rsv_o);

   always #4 clk = ~clk;

   i2c_regtarget #(.OWN_ADDR(MYADDR), .NUM_REGS(NREG)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_c), .sda_i(sda_line),
      .sda_o(sda_o), .sda_oe(sda_oe));

   // Second target whose own address lies in the reserved range.
   i2c_regtarget #(.OWN_ADDR(7'h7A), .NUM_REGS(NREG)) dut_rsv (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_c), .sda_i(sda_line),
      .sda_o(rsv_o), .sda_oe(rsv_oe));

   int checks = 0;
   int errors = 0;
   int r4_bad = 0;
   bit done = 0;
   logic [7:0] model [NREG];
   int mptr = 0;

   int    exp_q [$];
   string tag_q [$];
   int    obs_q [$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic expect_item(input int v, input string tag);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   // Scoreboard monitor: pairs each observed bus result with the oldest expectation.
   initial begin
      int a, e;
      string t;
      forever begin
         @(negedge clk);
         while (obs_q.size() > 0) begin
            a = obs_q.pop_front();
            if (exp_q.size() == 0) begin
               chk(1'b0, "scoreboard underflow", a, 0);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(a == e, t, a, e);
            end
         end
      end
   end

   // R4 watch: drive changes while SCL stayed high across two samples.
   initial begin
      logic oe_prev, scl_prev;
      oe_prev = 1'b0;
      scl_prev = 1'b1;
      forever begin
         @(negedge clk);
         if (rst_n && sda_oe !== oe_prev && scl_c && scl_prev) r4_bad++;
         oe_prev  = sda_oe;
         scl_prev = scl_c;
      end
   end

   task automatic tick();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_c = 1'b1; tick();
      scl_c = 1'b1; tick();
      sda_c = 1'b0; tick();
      scl_c = 1'b0; tick();
   endtask

   task automatic bus_stop();
      sda_c = 1'b0; tick();
      scl_c = 1'b1; tick();
      sda_c = 1'b1; tick();
      mptr = 0;
   endtask

   task automatic wbit(input logic b);
      sda_c = b;    tick();
      scl_c = 1'b1; tick(); tick();
      scl_c = 1'b0; tick();
   endtask

   task automatic rbit(output logic b);
      sda_c = 1'b1; tick();
      scl_c = 1'b1; tick();
      b = sda_line; tick();
      scl_c = 1'b0; tick();
   endtask

   task automatic send_byte(input logic [7:0] v, output bit ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(v[i]);
      rbit(b);
      ack = !b;
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         rbit(b);
         v[i] = b;
      end
      wbit(!give_ack);
   endtask

   // Driver: START, address (write), pointer byte, n data bytes.
   task automatic xfer_write(input logic [6:0] a, input logic [7:0] p, input int n,
                             input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                             input bit hit, input string tag);
      bit ack;
      logic [7:0] d;
      bus_start();
      expect_item(int'(hit), {tag, " address ack (R3)"});
      send_byte({a, 1'b0}, ack);
      obs_q.push_back(int'(ack));
      expect_item(int'(hit), {tag, " pointer ack (R6)"});
      send_byte(p, ack);
      obs_q.push_back(int'(ack));
      if (hit) mptr = int'(p) % NREG;
      for (int k = 0; k < n; k++) begin
         d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
         expect_item(int'(hit), {tag, " data ack (R6)"});
         send_byte(d, ack);
         obs_q.push_back(int'(ack));
         if (hit) begin
            model[mptr] = d;
            mptr = (mptr + 1) % NREG;
         end
      end
   endtask

   // Driver: (repeated) START, address (read), n bytes, last one NACKed.
   task automatic xfer_read(input int n, input string tag);
      bit ack;
      logic [7:0] v;
      bus_start();
      expect_item(1, {tag, " read address ack (R3)"});
      send_byte({MYADDR, 1'b1}, ack);
      obs_q.push_back(int'(ack));
      for (int k = 0; k < n; k++) begin
         expect_item(int'(model[mptr]), tag);
         recv_byte(k < n - 1, v);
         obs_q.push_back(int'(v));
         mptr = (mptr + 1) % NREG;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic b;
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;
      repeat (10) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 sda released in reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(sda_oe == 1'b0 && sda_line == 1'b1, "R1 idle after reset", int'(sda_oe), 0);

      // Burst write wrapping past the last register: pointer 6 -> 7 -> 0.
      xfer_write(MYADDR, 8'h06, 3, 8'hA1, 8'hB2, 8'hC3, 1'b1, "R6 wrap burst");
      bus_stop();

      // Pointer-only write, repeated START, read back across the wrap.
      xfer_write(MYADDR, 8'h06, 0, 8'h00, 8'h00, 8'h00, 1'b1, "R2 set pointer");
      xfer_read(3, "R7 R2 read after repeated START");
      // One more clock after the NACK: the line must stay released.
      rbit(b);
      chk(b == 1'b1 && sda_oe == 1'b0, "R8 released after NACK", int'(b), 1);
      bus_stop();

      // STOP reset the pointer: read starts at register 0.
      xfer_read(2, "R10 pointer zero after STOP");
      bus_stop();

      // Address mismatch: no acks, no register change.
      xfer_write(7'h43, 8'h00, 1, 8'h55, 8'h00, 8'h00, 1'b0, "R3 mismatch");
      chk(sda_oe == 1'b0, "R3 released on mismatch", int'(sda_oe), 0);
      bus_stop();

      // Reserved addresses, one matching the second target's own address.
      xfer_write(7'h7A, 8'h00, 1, 8'h66, 8'h00, 8'h00, 1'b0, "R5 reserved 1111");
      bus_stop();
      xfer_write(7'h03, 8'h00, 1, 8'h77, 8'h00, 8'h00, 1'b0, "R5 reserved 0000");
      bus_stop();

      // START immediately followed by STOP.
      bus_start();
      bus_stop();
      chk(sda_oe == 1'b0, "R9 released after bare START-STOP", int'(sda_oe), 0);
      xfer_read(NREG, "R9 R1 bank unchanged");
      bus_stop();

      // Read ended by NACK, then repeated START into a write, then read back.
      xfer_write(MYADDR, 8'h02, 0, 8'h00, 8'h00, 8'h00, 1'b1, "R8 pointer");
      xfer_read(1, "R8 single byte");
      xfer_write(MYADDR, 8'h03, 1, 8'h5A, 8'h00, 8'h00, 1'b1, "R8 recovery write");
      xfer_write(MYADDR, 8'h03, 0, 8'h00, 8'h00, 8'h00, 1'b1, "R8 pointer again");
      xfer_read(1, "R8 recovery readback");
      bus_stop();

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      chk(r4_bad == 0, "R4 drive change with SCL high", r4_bad, 0);
      finish_run();
   end
endmodule